// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an external asynchronous static RAM of 128K words by 16 bits. The host asks for one word at a time with a request pulse, a write flag, a word address, write data and per-byte enables. The controller turns each request into a timed sequence of chip-enable, output-enable, write-enable and byte-strobe levels. When an access is finished it puts the memory back into standby.

Every phase is a whole number of clock cycles. The lengths come from nanosecond minimums given as parameters, rounded up to the clock period. With the default 10 ns clock, a read holds its strobes for 6 cycles. A write holds write enable low for 5 cycles, with one setup cycle before and one recovery cycle after. An idle gap of 1 cycle follows every access.

The data bus is split into an output value, an input value and a drive enable. The controller turns its drive on only while the memory's output enable is inactive. It drops the drive one cycle after write enable rises, so a later read never meets a driven bus.

Top module: `sram_async_ctrl`

## Requirements
- R1: The memory is selected only when mem_ce_n is 0 and mem_ce2 is 1; the two chip enables always change together. Out of reset, and between accesses, mem_ce_n=1, mem_ce2=0, mem_oe_n=1, mem_we_n=1, mem_bs_n=2'b11 and mem_dq_oe=0.
- R2: A request is accepted on a clock edge where host_req=1 and host_busy=0, and host_busy is 1 from that edge on. It stays high for RD_CYCLES+GAP cycles for a read (7 by default) and for WE_CYCLES+2+GAP cycles for a write (8 by default).
- R3: During a read, chip select and mem_oe_n=0 are held for exactly RD_CYCLES cycles, with mem_we_n=1 and both byte strobes low. The bus value at the end of that window is returned on host_rdata, and host_rvalid is high for exactly one cycle.
- R4: During a write, mem_we_n is low for exactly WE_CYCLES consecutive cycles, and mem_oe_n stays 1 for the whole write.
- R5: In a write, host_be bit 0 drives mem_bs_n bit 0 low (data bits 7:0) and host_be bit 1 drives mem_bs_n bit 1 low (bits 15:8). Only the enabled bytes of the stored word change, and a write with host_be=0 changes nothing.
- R6: mem_addr takes the request's address one cycle after acceptance and holds it for the whole access. In particular it does not move while mem_we_n is low, and mem_dq_out carries the request's write data during the pulse.
- R7: mem_dq_oe is never 1 while mem_oe_n is 0. It is already 1 in the cycle before mem_we_n falls, is still 1 in the cycle where mem_we_n rises, and is 0 in the cycle after that.
- R8: In a write, chip select and the byte strobes are active for at least WE_CYCLES+1 cycles before mem_we_n rises, and mem_we_n is never low while the memory is deselected.
- R9: A request presented while host_busy=1 is ignored: it is not queued and it writes nothing.
- R10: Read data equals the last value written to that address, byte by byte, over any mix of reads and writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_req | input | 1 | Access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 17 | Word address |
| host_wdata | input | 16 | Write data |
| host_be | input | 2 | Byte enables, bit 0 = low byte |
| host_busy | output | 1 | Access in progress, requests ignored |
| host_rdata | output | 16 | Registered read data |
| host_rvalid | output | 1 | One-cycle read data valid |
| mem_addr | output | 17 | Memory address |
| mem_dq_out | output | 16 | Data driven to the memory |
| mem_dq_in | input | 16 | Data returned by the memory |
| mem_dq_oe | output | 1 | Controller drives the data bus |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_ce2 | output | 1 | Chip enable, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_bs_n | output | 2 | Byte strobes, active low, bit 0 = low byte |

## Verification
The hardest case to reach from the ports is a request that arrives while an access is still running and has to vanish without a trace. The only evidence is that no second write reaches the memory. The bench holds a write request to an address that has never been written, with high throughout a busy window, and drops it only after busy falls. A later read must still return that address's untouched initial content. Random traffic on a small pool of addresses then mixes partial-byte writes with reads back to back. This covers lane merging and the drive turnaround between a write and the next read.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_READ,
    PH_WSETUP,
    PH_WPULSE,
    PH_WRECOVER,
    PH_GAP
  } phase_t;

  function automatic int ceil_div(input int ns, input int period_ns);
    return (ns + period_ns - 1) / period_ns;
  endfunction

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  // Read strobes must cover cycle time, address access and output-enable access.
  function automatic int read_cycles(input int rc, input int aa, input int oe, input int per);
    return max3(ceil_div(rc, per), ceil_div(aa, per), ceil_div(oe, per));
  endfunction

  // The write-enable pulse alone must cover pulse width, select-to-end and data setup.
  function automatic int we_cycles(input int wp, input int cw, input int ds, input int per);
    return max3(ceil_div(wp, per), ceil_div(cw, per), ceil_div(ds, per));
  endfunction

  function automatic logic phase_selects(input phase_t ph);
    return (ph == PH_READ) || (ph == PH_WSETUP) || (ph == PH_WPULSE);
  endfunction

  function automatic logic phase_drives(input phase_t ph);
    return (ph == PH_WSETUP) || (ph == PH_WPULSE) || (ph == PH_WRECOVER);
  endfunction

endpackage

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
  import sram_ctrl_pkg::*;
#(
  parameter int RD_CYCLES  = 6,
  parameter int WE_CYCLES  = 5,
  parameter int GAP_CYCLES = 1
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   req,
  input  logic   we,
  output phase_t phase_q,
  output phase_t phase_d,
  output logic   accept_evt,
  output logic   sample_evt
);
  localparam int MAXC  = max3(RD_CYCLES, WE_CYCLES, GAP_CYCLES);
  localparam int CNT_W = (MAXC < 2) ? 1 : $clog2(MAXC);
  localparam logic [CNT_W-1:0] RD_LAST  = CNT_W'(RD_CYCLES - 1);
  localparam logic [CNT_W-1:0] WE_LAST  = CNT_W'(WE_CYCLES - 1);
  localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_zero;

  assign cnt_zero   = (cnt_q == '0);
  assign accept_evt = (phase_q == PH_IDLE) && req;
  assign sample_evt = (phase_q == PH_READ) && cnt_zero;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    case (phase_q)
      PH_IDLE: begin
        if (req) begin
          if (we) begin
            phase_d = PH_WSETUP;
            cnt_d   = '0;
          end else begin
            phase_d = PH_READ;
            cnt_d   = RD_LAST;
          end
        end
      end
      PH_READ: begin
        if (cnt_zero) begin
          phase_d = PH_GAP;
          cnt_d   = GAP_LAST;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_WSETUP: begin
        phase_d = PH_WPULSE;
        cnt_d   = WE_LAST;
      end
      PH_WPULSE: begin
        if (cnt_zero) begin
          phase_d = PH_WRECOVER;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_WRECOVER: begin
        phase_d = PH_GAP;
        cnt_d   = GAP_LAST;
      end
      PH_GAP: begin
        if (cnt_zero) begin
          phase_d = PH_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen
  import sram_ctrl_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  phase_t           phase_d,
  input  logic [LANES-1:0] lane_en,
  output logic             ce_n,
  output logic             ce2,
  output logic             oe_n,
  output logic             we_n,
  output logic [LANES-1:0] bs_n,
  output logic             dq_oe
);
  logic             sel_d;
  logic [LANES-1:0] bs_d;

  assign sel_d = phase_selects(phase_d);

  always_comb begin
    case (phase_d)
      PH_READ:              bs_d = '0;
      PH_WSETUP, PH_WPULSE: bs_d = ~lane_en;
      default:              bs_d = '1;
    endcase
  end

  // All memory strobes leave flops so no decode glitch reaches the pins.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n  <= 1'b1;
      ce2   <= 1'b0;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      bs_n  <= '1;
      dq_oe <= 1'b0;
    end else begin
      ce_n  <= ~sel_d;
      ce2   <= sel_d;
      oe_n  <= (phase_d != PH_READ);
      we_n  <= (phase_d != PH_WPULSE);
      bs_n  <= bs_d;
      dq_oe <= phase_drives(phase_d);
    end
  end

endmodule

// File: rtl/sram_host_regs.sv
module sram_host_regs #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              sample,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [LANES-1:0]  in_be,
  input  logic [DATA_W-1:0] bus_in,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q,
  output logic [LANES-1:0]  be_q,
  output logic [DATA_W-1:0] rdata_q,
  output logic              rvalid_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
    end else if (accept) begin
      addr_q  <= in_addr;
      wdata_q <= in_wdata;
      be_q    <= in_be;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= sample;
      if (sample) rdata_q <= bus_in;
    end
  end

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W        = 17,
  parameter int DATA_W        = 16,
  parameter int CLK_PERIOD_NS = 10,
  parameter int T_RC_NS       = 55,
  parameter int T_AA_NS       = 55,
  parameter int T_OE_NS       = 25,
  parameter int T_WP_NS       = 40,
  parameter int T_CW_NS       = 45,
  parameter int T_DS_NS       = 25,
  parameter int IDLE_CYCLES   = 1,
  localparam int LANES        = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic [LANES-1:0]  host_be,
  output logic              host_busy,
  output logic [DATA_W-1:0] host_rdata,
  output logic              host_rvalid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe,
  output logic              mem_ce_n,
  output logic              mem_ce2,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [LANES-1:0]  mem_bs_n
);
  localparam int RD_CYCLES  = read_cycles(T_RC_NS, T_AA_NS, T_OE_NS, CLK_PERIOD_NS);
  localparam int WE_CYCLES  = we_cycles(T_WP_NS, T_CW_NS, T_DS_NS, CLK_PERIOD_NS);
  localparam int GAP_CYCLES = (IDLE_CYCLES < 1) ? 1 : IDLE_CYCLES;

  phase_t           phase_q, phase_d;
  logic             accept_evt, sample_evt;
  logic [LANES-1:0] be_q, lane_sel;

  sram_phase_seq #(
    .RD_CYCLES (RD_CYCLES),
    .WE_CYCLES (WE_CYCLES),
    .GAP_CYCLES(GAP_CYCLES)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (host_req),
    .we        (host_we),
    .phase_q   (phase_q),
    .phase_d   (phase_d),
    .accept_evt(accept_evt),
    .sample_evt(sample_evt)
  );

  sram_host_regs #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .accept  (accept_evt),
    .sample  (sample_evt),
    .in_addr (host_addr),
    .in_wdata(host_wdata),
    .in_be   (host_be),
    .bus_in  (mem_dq_in),
    .addr_q  (mem_addr),
    .wdata_q (mem_dq_out),
    .be_q    (be_q),
    .rdata_q (host_rdata),
    .rvalid_q(host_rvalid)
  );

  // Strobes for the first write cycle are built from the request itself.
  assign lane_sel = accept_evt ? host_be : be_q;

  sram_strobe_gen #(
    .LANES(LANES)
  ) u_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase_d(phase_d),
    .lane_en(lane_sel),
    .ce_n   (mem_ce_n),
    .ce2    (mem_ce2),
    .oe_n   (mem_oe_n),
    .we_n   (mem_we_n),
    .bs_n   (mem_bs_n),
    .dq_oe  (mem_dq_oe)
  );

  assign host_busy = (phase_q != PH_IDLE);

endmodule

// File: rtl/sram_async_ctrl_chk.sv
module sram_async_ctrl_chk #(
  parameter int ADDR_W    = 17,
  parameter int WE_CYCLES = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_busy,
  input logic              host_rvalid,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe,
  input logic              mem_ce_n,
  input logic              mem_ce2,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic              accept_evt,
  input logic              sample_evt
);
  logic [7:0] we_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         we_run <= '0;
    else if (!mem_we_n) we_run <= we_run + 8'd1;
    else                we_run <= '0;
  end

  assert_sel_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_ce_n == ~mem_ce2));

  assert_busy_after_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> host_busy);

  assert_rvalid_follows_sample_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |=> host_rvalid);

  assert_rvalid_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    host_rvalid |=> !host_rvalid);

  assert_oe_high_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  assert_we_pulse_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (we_run == 8'(WE_CYCLES)));

  assert_addr_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && $past(!mem_we_n)) |-> $stable(mem_addr));

  assert_no_contention_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_dq_oe && !mem_oe_n));

  assert_drive_at_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> mem_dq_oe);

  assert_drive_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |=> !mem_dq_oe);

  assert_we_needs_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_ce2));

endmodule

bind sram_async_ctrl sram_async_ctrl_chk #(
  .ADDR_W   (ADDR_W),
  .WE_CYCLES(WE_CYCLES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_busy  (host_busy),
  .host_rvalid(host_rvalid),
  .mem_addr   (mem_addr),
  .mem_dq_oe  (mem_dq_oe),
  .mem_ce_n   (mem_ce_n),
  .mem_ce2    (mem_ce2),
  .mem_oe_n   (mem_oe_n),
  .mem_we_n   (mem_we_n),
  .accept_evt (accept_evt),
  .sample_evt (sample_evt)
);

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;
  localparam int AW = 17;
  localparam int DW = 16;
  localparam int RD_C = 6;   // ceil(55 ns / 10 ns)
  localparam int WE_C = 5;   // ceil(45 ns / 10 ns)
  localparam int GAP_C = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          host_req = 1'b0, host_we = 1'b0;
  logic [AW-1:0] host_addr = '0;
  logic [DW-1:0] host_wdata = '0;
  logic [1:0]    host_be = '0;
  logic          host_busy, host_rvalid;
  logic [DW-1:0] host_rdata;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in = '0;
  logic          mem_dq_oe, mem_ce_n, mem_ce2, mem_oe_n, mem_we_n;
  logic [1:0]    mem_bs_n;

  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  sram_async_ctrl u_sram_async_ctrl (
    .clk(clk), .rst_n(rst_n),
    .host_req(host_req), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_be(host_be),
    .host_busy(host_busy), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in),
    .mem_dq_oe(mem_dq_oe), .mem_ce_n(mem_ce_n), .mem_ce2(mem_ce2),
    .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_bs_n(mem_bs_n)
  );

  function automatic logic [DW-1:0] init_word(input logic [AW-1:0] a);
    return {a[7:0] ^ 8'hC3, a[15:8] ^ 8'h5A};
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old, input logic [DW-1:0] nw,
                                           input logic [1:0] be);
    logic [DW-1:0] r;
    r = old;
    if (be[0]) r[7:0]  = nw[7:0];
    if (be[1]) r[15:8] = nw[15:8];
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural memory plus a separate expected image
  logic [DW-1:0] ram [logic [AW-1:0]];
  logic [DW-1:0] shadow [logic [AW-1:0]];

  function automatic logic [DW-1:0] shadow_rd(input logic [AW-1:0] a);
    return shadow.exists(a) ? shadow[a] : init_word(a);
  endfunction

  // Monitor state
  logic          cur_wr_valid = 1'b0;
  logic [AW-1:0] cur_addr = '0;
  logic [DW-1:0] cur_wdata = '0;
  logic [1:0]    cur_be = '0;
  int  we_run = 0, oe_run = 0, sel_run = 0;
  bit  prev_we = 1'b1, prev_oe_drv = 1'b0, tail_pending = 1'b0;
  int  v_sel = 0, v_cont = 0, v_pulse = 0, v_oe = 0, v_wr = 0, v_drive = 0, v_ce = 0;
  int  n_pulses = 0, n_reads = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic sel;
      logic [DW-1:0] w;
      sel = !mem_ce_n && mem_ce2;
      if ((mem_ce_n == 1'b0) != (mem_ce2 == 1'b1)) v_sel++;              // R1
      if (!host_busy && (sel || !mem_oe_n || !mem_we_n || mem_dq_oe || mem_bs_n != 2'b11)) v_sel++;
      if (mem_dq_oe && !mem_oe_n) v_cont++;                             // R7
      if (!mem_we_n && !sel) v_ce++;                                   // R8
      if (tail_pending) begin
        if (mem_dq_oe) v_drive++;
        tail_pending = 1'b0;
      end
      if (prev_we && !mem_we_n && !prev_oe_drv) v_drive++;             // R7 drive before fall
      if (!prev_we && mem_we_n) begin
        n_pulses++;
        if (we_run != WE_C) v_pulse++;                                 // R4
        if (sel_run < WE_C + 1) v_ce++;                                // R8
        if (!mem_dq_oe) v_drive++;
        tail_pending = 1'b1;
      end
      if (!mem_we_n) begin
        if (!mem_oe_n) v_pulse++;
        if (!cur_wr_valid || mem_addr != cur_addr || mem_dq_out != cur_wdata
            || mem_bs_n != ~cur_be) v_wr++;                            // R5 R6
      end
      if (!mem_oe_n) begin
        if (!mem_we_n || mem_bs_n != 2'b00 || !sel) v_oe++;            // R3
        oe_run++;
      end else if (oe_run != 0) begin
        n_reads++;
        if (oe_run != RD_C) v_oe++;
        oe_run = 0;
      end
      we_run  = mem_we_n ? 0 : we_run + 1;
      sel_run = sel ? sel_run + 1 : 0;
      prev_we = mem_we_n;
      prev_oe_drv = mem_dq_oe;
      // memory array
      if (sel && !mem_we_n) begin
        w = ram.exists(mem_addr) ? ram[mem_addr] : init_word(mem_addr);
        ram[mem_addr] = merge(w, mem_dq_out, ~mem_bs_n);
      end
      if (sel && !mem_oe_n && mem_we_n) begin
        w = ram.exists(mem_addr) ? ram[mem_addr] : init_word(mem_addr);
        mem_dq_in = {mem_bs_n[1] ? 8'h00 : w[15:8], mem_bs_n[0] ? 8'h00 : w[7:0]};
      end else begin
        mem_dq_in = '0;
      end
    end
  end

  task automatic run_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [1:0] be, input bit hold_junk);
    int busy_n, rv_n;
    logic [DW-1:0] got;
    @(negedge clk);
    host_req = 1'b1; host_we = wr; host_addr = a; host_wdata = d; host_be = be;
    cur_wr_valid = wr; cur_addr = a; cur_wdata = d; cur_be = be;
    @(negedge clk);
    check("R2 busy after accept", host_busy, 1'b1);
    check("R6 address presented", mem_addr, a);
    if (hold_junk) begin
      host_we = 1'b1; host_addr = 17'h1F0F0; host_wdata = 16'hBAD0; host_be = 2'b11;
    end else begin
      host_req = 1'b0;
    end
    busy_n = 1; rv_n = 0; got = '0;
    while (host_busy) begin
      if (host_rvalid) begin rv_n++; got = host_rdata; end
      @(negedge clk);
      if (host_busy) busy_n++;
    end
    if (host_rvalid) begin rv_n++; got = host_rdata; end
    host_req = 1'b0;
    cur_wr_valid = 1'b0;
    check(wr ? "R2 write busy length" : "R2 read busy length", busy_n,
          wr ? (WE_C + 2 + GAP_C) : (RD_C + GAP_C));
    if (wr) begin
      shadow[a] = merge(shadow_rd(a), d, be);
      check("R3 no rvalid on write", rv_n, 0);
    end else begin
      check("R3 rvalid single pulse", rv_n, 1);
      check("R10 read data", got, shadow_rd(a));
    end
  endtask

  initial begin
    void'($urandom(32'd20240607));
    repeat (3) @(negedge clk);
    check("R1 reset ce_n", mem_ce_n, 1'b1);
    check("R1 reset ce2", mem_ce2, 1'b0);
    check("R1 reset oe/we", {mem_oe_n, mem_we_n}, 2'b11);
    check("R1 reset bs/drive", {mem_bs_n, mem_dq_oe}, 3'b110);
    check("R2 reset busy", {host_busy, host_rvalid}, 2'b00);
    rst_n = 1'b1;

    // Directed byte lanes
    run_op(1'b1, 17'h00010, 16'h1234, 2'b11, 1'b0);
    run_op(1'b1, 17'h00010, 16'hAB00 | 16'h00CD, 2'b01, 1'b0);  // R5 low only
    run_op(1'b0, 17'h00010, '0, 2'b11, 1'b0);
    check("R5 low lane merge", shadow_rd(17'h00010), 16'h12CD);
    run_op(1'b1, 17'h00010, 16'hEF99, 2'b10, 1'b0);             // R5 high only
    run_op(1'b0, 17'h00010, '0, 2'b11, 1'b0);
    run_op(1'b1, 17'h00010, 16'h0000, 2'b00, 1'b0);             // R5 no lanes
    run_op(1'b0, 17'h00010, '0, 2'b11, 1'b0);
    check("R5 empty enable keeps word", shadow_rd(17'h00010), 16'hEFCD);
    // Top address boundary
    run_op(1'b1, 17'h1FFFF, 16'h5AA5, 2'b11, 1'b0);
    run_op(1'b0, 17'h1FFFF, '0, 2'b11, 1'b0);
    run_op(1'b0, 17'h00000, '0, 2'b11, 1'b0);
    // R9: request held during busy must be dropped
    run_op(1'b0, 17'h00020, '0, 2'b11, 1'b1);
    run_op(1'b1, 17'h00021, 16'h7777, 2'b11, 1'b1);
    run_op(1'b0, 17'h1F0F0, '0, 2'b11, 1'b0);
    check("R9 held request wrote nothing", ram.exists(17'h1F0F0), 1'b0);

    // Constrained random on a small pool
    for (int i = 0; i < 300; i++) begin
      logic [AW-1:0] a;
      a = 17'h0A000 | AW'($urandom_range(0, 15));
      run_op(1'($urandom_range(0, 1)), a, DW'($urandom), 2'($urandom_range(0, 3)), 1'b0);
    end

    check("R1 select pair and standby", v_sel, 0);
    check("R3 read strobe window", v_oe, 0);
    check("R3 reads observed", n_reads > 20, 1'b1);
    check("R4 write pulse length", v_pulse, 0);
    check("R4 pulses observed", n_pulses > 20, 1'b1);
    check("R5 R6 lanes/address/data in pulse", v_wr, 0);
    check("R7 bus contention", v_cont, 0);
    check("R7 drive timing", v_drive, 0);
    check("R8 select before write end", v_ce, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule